// File: doc/BRIEF.md
# Guest Exit Decision Unit

This unit sits beside a processor core that runs guest code under a host monitor. For every guest event the core reports (an external interrupt, a change of the guest interrupt mask, an exception, a control-register access, a port access, a model-specific register access or a privileged instruction), the unit decides whether the event must leave guest mode. If it must, the unit also gives a three-bit reason code. Some accesses are served locally and never exit: control-register reads return a shadow value, and task-priority accesses use a shadow copy when that option is on.

The host monitor loads the controls through a simple write port. The controls are the enable bits, an exception bitmap with a page-fault qualifier, and a write mask and read shadow for each control register. Port and model-specific-register permissions live in an external bitmap memory. The unit reads that memory through a synchronous read port with one cycle of latency. Events arrive on a valid/ready handshake. Each accepted event yields exactly one single-cycle decision pulse.

Top module: `guest_exit_unit`

## Requirements
- R1: With the external-interrupt exit enable set (control word bit 0), an event of type 0 exits with reason 0, whatever the guest interrupt mask is. With the enable clear, it does not exit.
- R2: An event of type 1 carries the new guest mask in data bit 0, where 1 means masked. It exits with reason 1 only when the window exit enable (control word bit 1) is set and the mask goes from masked to unmasked. The unit stores the new mask on every such event. The stored mask is masked after reset.
- R3: An event of type 3 is a write to the control register selected by the low index bits. It exits with reason 3 exactly when the written data differs from that register's shadow in some bit that is set in the register's mask. Otherwise it completes without exit.
- R4: An event of type 4 is a control-register read. It returns the selected register's shadow on the value output and never exits.
- R5: With the task-priority shadow enable set (control word bit 2), type 8 (priority read) returns the 4-bit shadow and type 9 (priority write) loads data bits 3:0 into the shadow, both without exit. With the enable clear, both exit with reason 3.
- R6: An event of type 2 with an exception vector in index bits 4:0 other than 14 exits with reason 2 exactly when that vector's bit in the exception bitmap is set.
- R7: For vector 14, the error code in the data is qualified: the event exits when ((error AND pf_mask) == pf_match) equals bitmap bit 14, and does not exit otherwise.
- R8: An event of type 5 is an access to port p (index bits 15:0). It exits with reason 4 exactly when bit p%32 of bitmap word p/32 is set.
- R9: Types 6 and 7 are reads and writes of MSR i. If i < 256, the event exits (reason 5 for a read, 6 for a write) exactly when bit i%32 is set in word 2048 + i/32 (read) or word 2056 + i/32 (write). An index of 256 or more always exits, with the same reason codes.
- R10: Event types 10 to 15 always exit with reason 7.
- R11: A decision appears one cycle after acceptance, or two cycles after for events that read the bitmap (types 5 to 7 in range). While that read is pending, ready is low. Each accepted event gives exactly one decision.
- R12: After reset, no decision is valid, ready is high, and all controls and shadows are zero. The reason output is 0 and the value output is 0 whenever the decision does not use them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_addr | input | 4 | Control select: 0 enables, 1 exception bitmap, 2 pf_mask, 3 pf_match, 4 priority shadow, 8+2n mask of register n, 9+2n shadow of register n |
| cfg_wdata | input | 32 | Control write data |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event can be taken |
| ev_type | input | 4 | Event type code |
| ev_idx | input | 16 | Vector, register number, port or MSR index |
| ev_data | input | 32 | Written value, new mask or error code |
| mem_rd_en | output | 1 | Bitmap memory read strobe |
| mem_addr | output | 12 | Bitmap word address |
| mem_rdata | input | 32 | Bitmap word, one cycle after the strobe |
| dec_valid | output | 1 | Decision pulse |
| dec_exit | output | 1 | Event leaves guest mode |
| dec_reason | output | 3 | Exit reason code |
| dec_value | output | 32 | Value returned to the guest |

## Verification
The assertions check the handshake timing of R11 on every cycle: the stall during a bitmap lookup, the fixed decision latency, and that no lookup is issued without acceptance. They also check the behaviours that never depend on stored data: forced external-interrupt exits, exit-free control-register reads and unconditional exits. The bench scenarios are needed for the data-dependent decisions. These are the mask comparison against shadows, both polarities of the page-fault qualifier, the window edge that depends on the previous mask, the priority shadow update, and the bit selection inside the bitmap words. For these, the bench compares each decision against its own model of the controls and of the memory contents.

// File: rtl/guest_exit_unit.sv
module guest_exit_unit #(
  parameter int NUM_CR = 4,
  parameter int DW     = 32,
  parameter int IDX_W  = 16,
  parameter int PORT_W = 16,
  parameter int MSR_W  = 8,
  parameter int TPR_W  = 4,
  parameter int PF_VEC = 14,
  localparam int BIT_W     = $clog2(DW),
  localparam int IO_WORDS  = (1 << PORT_W) / DW,
  localparam int MSR_WORDS = (1 << MSR_W) / DW,
  localparam int MEM_AW    = $clog2(IO_WORDS + 2 * MSR_WORDS),
  localparam int CFG_AW    = $clog2(8 + 2 * NUM_CR),
  localparam int CR_IW     = $clog2(NUM_CR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [3:0]        ev_type,
  input  logic [IDX_W-1:0]  ev_idx,
  input  logic [DW-1:0]     ev_data,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [DW-1:0]     mem_rdata,
  output logic              dec_valid,
  output logic              dec_exit,
  output logic [2:0]        dec_reason,
  output logic [DW-1:0]     dec_value
);

  localparam logic [3:0] T_EXT = 4'd0, T_MASK = 4'd1, T_EXC = 4'd2, T_CRW = 4'd3,
                         T_CRR = 4'd4, T_IO = 4'd5, T_MSRR = 4'd6, T_MSRW = 4'd7,
                         T_TPRR = 4'd8, T_TPRW = 4'd9;

  logic              ext_en, win_en, tpr_en, g_masked;
  logic [DW-1:0]     exc_bm, pf_mask, pf_match;
  logic [TPR_W-1:0]  tpr_sh;
  logic [DW-1:0]     cr_mask [NUM_CR];
  logic [DW-1:0]     cr_sh   [NUM_CR];
  logic              pend;
  logic [2:0]        pend_reason;
  logic [BIT_W-1:0]  pend_bit;

  logic              accept, is_msr, msr_oor, use_mem;
  logic [CR_IW-1:0]  cr_i;
  logic [BIT_W-1:0]  vec;
  logic              pf_hit;
  logic              im_exit;
  logic [2:0]        im_reason;
  logic [DW-1:0]     im_value;

  assign ev_ready  = !pend;
  assign accept    = ev_valid && ev_ready;
  assign is_msr    = (ev_type == T_MSRR) || (ev_type == T_MSRW);
  assign msr_oor   = |ev_idx[IDX_W-1:MSR_W];
  assign use_mem   = (ev_type == T_IO) || (is_msr && !msr_oor);
  assign mem_rd_en = accept && use_mem;
  assign cr_i      = ev_idx[CR_IW-1:0];
  assign vec       = ev_idx[BIT_W-1:0];
  assign pf_hit    = (ev_data & pf_mask) == pf_match;

  always_comb begin
    if (ev_type == T_IO)
      mem_addr = MEM_AW'(ev_idx[PORT_W-1:BIT_W]);
    else if (ev_type == T_MSRR)
      mem_addr = MEM_AW'(IO_WORDS) + MEM_AW'(ev_idx[MSR_W-1:BIT_W]);
    else
      mem_addr = MEM_AW'(IO_WORDS + MSR_WORDS) + MEM_AW'(ev_idx[MSR_W-1:BIT_W]);
  end

  always_comb begin
    im_exit   = 1'b0;
    im_reason = 3'd0;
    im_value  = '0;
    case (ev_type)
      T_EXT:  begin im_exit = ext_en; im_reason = 3'd0; end
      T_MASK: begin im_exit = win_en && g_masked && !ev_data[0]; im_reason = 3'd1; end
      T_EXC:  begin
        im_reason = 3'd2;
        if (int'(vec) == PF_VEC) im_exit = exc_bm[vec] ^ !pf_hit;
        else                     im_exit = exc_bm[vec];
      end
      T_CRW:  begin im_exit = |((ev_data ^ cr_sh[cr_i]) & cr_mask[cr_i]); im_reason = 3'd3; end
      T_CRR:  im_value = cr_sh[cr_i];
      T_IO:   im_reason = 3'd4;
      T_MSRR: begin im_exit = msr_oor; im_reason = 3'd5; end
      T_MSRW: begin im_exit = msr_oor; im_reason = 3'd6; end
      T_TPRR: begin
        im_exit = !tpr_en; im_reason = 3'd3;
        if (tpr_en) im_value = DW'(tpr_sh);
      end
      T_TPRW: begin im_exit = !tpr_en; im_reason = 3'd3; end
      default: begin im_exit = 1'b1; im_reason = 3'd7; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_en   <= 1'b0;
      win_en   <= 1'b0;
      tpr_en   <= 1'b0;
      exc_bm   <= '0;
      pf_mask  <= '0;
      pf_match <= '0;
      tpr_sh   <= '0;
      for (int i = 0; i < NUM_CR; i++) begin
        cr_mask[i] <= '0;
        cr_sh[i]   <= '0;
      end
    end else begin
      if (cfg_we) begin
        case (int'(cfg_addr))
          0: {tpr_en, win_en, ext_en} <= cfg_wdata[2:0];
          1: exc_bm   <= cfg_wdata;
          2: pf_mask  <= cfg_wdata;
          3: pf_match <= cfg_wdata;
          4: tpr_sh   <= cfg_wdata[TPR_W-1:0];
          default: ;
        endcase
        for (int i = 0; i < NUM_CR; i++) begin
          if (int'(cfg_addr) == 8 + 2 * i) cr_mask[i] <= cfg_wdata;
          if (int'(cfg_addr) == 9 + 2 * i) cr_sh[i]   <= cfg_wdata;
        end
      end
      if (accept && ev_type == T_TPRW && tpr_en) tpr_sh <= ev_data[TPR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g_masked    <= 1'b1;
      pend        <= 1'b0;
      pend_reason <= 3'd0;
      pend_bit    <= '0;
      dec_valid   <= 1'b0;
      dec_exit    <= 1'b0;
      dec_reason  <= 3'd0;
      dec_value   <= '0;
    end else begin
      if (accept && ev_type == T_MASK) g_masked <= ev_data[0];
      if (accept && !use_mem) begin
        dec_valid  <= 1'b1;
        dec_exit   <= im_exit;
        dec_reason <= im_exit ? im_reason : 3'd0;
        dec_value  <= im_value;
      end else if (pend) begin
        pend       <= 1'b0;
        dec_valid  <= 1'b1;
        dec_exit   <= mem_rdata[pend_bit];
        dec_reason <= mem_rdata[pend_bit] ? pend_reason : 3'd0;
        dec_value  <= '0;
      end else begin
        dec_valid  <= 1'b0;
      end
      if (accept && use_mem) begin
        pend        <= 1'b1;
        pend_bit    <= ev_idx[BIT_W-1:0];
        pend_reason <= im_reason;
      end
    end
  end

endmodule

// File: rtl/guest_exit_unit_chk.sv
module guest_exit_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_valid,
  input logic       ev_ready,
  input logic [3:0] ev_type,
  input logic       mem_rd_en,
  input logic       dec_valid,
  input logic       dec_exit,
  input logic [2:0] dec_reason,
  input logic       ext_en
);
  logic acc;
  assign acc = ev_valid && ev_ready;

  AST_IO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ev_type == 4'd5) |=> (!ev_ready && !dec_valid)); // R11
  AST_IO_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ev_type == 4'd5) |-> ##2 dec_valid); // R11
  AST_DIRECT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (ev_type <= 4'd4 || ev_type == 4'd8 || ev_type == 4'd9)) |=> dec_valid); // R11
  AST_LOOKUP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (ev_valid && ev_ready)); // R11
  AST_EXT_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ev_type == 4'd0 && ext_en) |=> (dec_exit && dec_reason == 3'd0)); // R1
  AST_CR_READ_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ev_type == 4'd4) |=> !dec_exit); // R4
  AST_UNCOND_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ev_type >= 4'd10) |=> (dec_exit && dec_reason == 3'd7)); // R10
endmodule

bind guest_exit_unit guest_exit_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .ev_type(ev_type), .mem_rd_en(mem_rd_en), .dec_valid(dec_valid),
  .dec_exit(dec_exit), .dec_reason(dec_reason), .ext_en(ext_en)
);

// File: tb/guest_exit_unit_bench.sv
module guest_exit_unit_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [3:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic        ev_valid = 0;
  logic        ev_ready;
  logic [3:0]  ev_type = 0;
  logic [15:0] ev_idx = 0;
  logic [31:0] ev_data = 0;
  logic        mem_rd_en;
  logic [11:0] mem_addr;
  logic [31:0] mem_rdata = 0;
  logic        dec_valid, dec_exit;
  logic [2:0]  dec_reason;
  logic [31:0] dec_value;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #10 clk = ~clk;

  guest_exit_unit u_guest_exit_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_type(ev_type), .ev_idx(ev_idx),
    .ev_data(ev_data), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .dec_valid(dec_valid), .dec_exit(dec_exit), .dec_reason(dec_reason), .dec_value(dec_value)
  );

  function automatic logic [31:0] bm_word(input int a);
    logic [31:0] x;
    x = a * 32'h9E3779B1;
    return x ^ (x >> 13) ^ 32'h5A3C_96E1;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rdata <= bm_word(int'(mem_addr));

  logic        m_ext, m_win, m_tpr_en, m_masked;
  logic [31:0] m_exc, m_pfm, m_pfmt;
  logic [3:0]  m_tpr;
  logic [31:0] m_crm [4];
  logic [31:0] m_crs [4];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = d;
    case (a)
      0: {m_tpr_en, m_win, m_ext} = d[2:0];
      1: m_exc = d;
      2: m_pfm = d;
      3: m_pfmt = d;
      4: m_tpr = d[3:0];
      default: if (a >= 8) begin
        if (a % 2 == 0) m_crm[(a - 8) / 2] = d; else m_crs[(a - 9) / 2] = d;
      end
    endcase
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic run_ev(input logic [3:0] t, input logic [15:0] idx, input logic [31:0] d);
    logic ex; logic [2:0] rs; logic [31:0] val; int lat; int w; string tag; logic hit;
    ex = 0; rs = 0; val = 0; lat = 1;
    case (t)
      0: begin tag = "R1"; ex = m_ext; end
      1: begin tag = "R2"; ex = m_win && m_masked && !d[0]; rs = 1; m_masked = d[0]; end
      2: begin
        rs = 2;
        if (idx[4:0] == 5'd14) begin
          tag = "R7"; hit = (d & m_pfm) == m_pfmt;
          ex = hit ? m_exc[14] : !m_exc[14];
        end else begin tag = "R6"; ex = m_exc[idx[4:0]]; end
      end
      3: begin tag = "R3"; rs = 3; ex = ((d ^ m_crs[idx[1:0]]) & m_crm[idx[1:0]]) != 0; end
      4: begin tag = "R4"; val = m_crs[idx[1:0]]; end
      5: begin tag = "R8"; rs = 4; lat = 2; w = int'(idx) / 32; ex = bm_word(w)[idx[4:0]]; end
      6, 7: begin
        tag = "R9"; rs = (t == 6) ? 3'd5 : 3'd6;
        if (idx >= 256) ex = 1;
        else begin
          lat = 2; w = 2048 + ((t == 7) ? 8 : 0) + int'(idx) / 32;
          ex = bm_word(w)[idx[4:0]];
        end
      end
      8: begin tag = "R5"; rs = 3; ex = !m_tpr_en; if (m_tpr_en) val = {28'd0, m_tpr}; end
      9: begin tag = "R5"; rs = 3; ex = !m_tpr_en; if (m_tpr_en) m_tpr = d[3:0]; end
      default: begin tag = "R10"; ex = 1; rs = 7; end
    endcase
    if (!ex) rs = 0;
    @(negedge clk);
    while (!ev_ready) @(negedge clk);
    ev_valid = 1; ev_type = t; ev_idx = idx; ev_data = d;
    @(negedge clk);
    ev_valid = 0;
    if (lat == 2) chk(!ev_ready, "R11 ready low during lookup", 32'(ev_ready), 0);
    w = 1;
    while (!dec_valid && w < 4) begin @(negedge clk); w++; end
    chk(w == lat, {tag, " R11 latency"}, w, lat);
    chk(dec_exit == ex, {tag, " exit"}, 32'(dec_exit), 32'(ex));
    chk(dec_reason == rs, {tag, " reason"}, 32'(dec_reason), 32'(rs));
    chk(dec_value == val, {tag, " R12 value"}, dec_value, val);
    @(negedge clk);
    chk(!dec_valid, "R11 single decision", 32'(dec_valid), 0);
  endtask

  task automatic rand_cfg();
    logic [31:0] mk;
    cfg(0, $urandom % 8);
    cfg(1, $urandom);
    mk = $urandom;
    cfg(2, mk);
    cfg(3, $urandom & mk);
    cfg(4, $urandom % 16);
    for (int i = 0; i < 4; i++) begin
      cfg(8 + 2 * i, $urandom);
      cfg(9 + 2 * i, $urandom);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [3:0] t; logic [15:0] idx; logic [31:0] d;
    void'($urandom(32'd2718));
    m_ext = 0; m_win = 0; m_tpr_en = 0; m_masked = 1;
    m_exc = 0; m_pfm = 0; m_pfmt = 0; m_tpr = 0;
    for (int i = 0; i < 4; i++) begin m_crm[i] = 0; m_crs[i] = 0; end
    repeat (3) @(negedge clk);
    chk(!dec_valid, "R12 no decision in reset", 32'(dec_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(ev_ready, "R12 ready after reset", 32'(ev_ready), 1);
    chk(!dec_valid, "R12 idle after reset", 32'(dec_valid), 0);
    run_ev(4, 2, 0);
    run_ev(0, 0, 0);
    run_ev(1, 0, 0);

    cfg(0, 3'b011);
    run_ev(1, 0, 1);
    run_ev(1, 0, 0);
    run_ev(1, 0, 0);
    run_ev(1, 0, 1);
    run_ev(0, 0, 0);
    run_ev(1, 0, 0);
    run_ev(0, 0, 0);

    cfg(8, 32'h0000_00F0); cfg(9, 32'h1234_5678);
    run_ev(3, 0, 32'h1234_560F);
    run_ev(3, 0, 32'h1234_5688);
    run_ev(4, 0, 0);

    cfg(1, 32'h0000_4001); cfg(2, 32'h0000_0003); cfg(3, 32'h0000_0001);
    run_ev(2, 14, 32'h0000_0005);
    run_ev(2, 14, 32'h0000_0002);
    run_ev(2, 0, 0);
    run_ev(2, 1, 0);
    cfg(1, 32'h0);
    run_ev(2, 14, 32'h1);
    run_ev(2, 14, 32'h0);

    run_ev(5, 16'hFFFF, 0);
    run_ev(5, 16'h0000, 0);
    run_ev(6, 255, 0);
    run_ev(7, 0, 0);
    run_ev(6, 256, 0);
    run_ev(7, 16'hFFFF, 0);

    run_ev(8, 0, 0);
    run_ev(9, 0, 9);
    cfg(0, 3'b100); cfg(4, 5);
    run_ev(8, 0, 0);
    run_ev(9, 0, 32'hC);
    run_ev(8, 0, 0);
    run_ev(10, 0, 0);
    run_ev(15, 0, 0);

    for (int n = 0; n < 600; n++) begin
      if (n % 60 == 0) rand_cfg();
      t = 4'($urandom % 16);
      idx = 16'($urandom);
      d = $urandom;
      if (t == 2 && $urandom % 3 == 0) idx = 14;
      if (t == 2 && idx[4:0] == 14 && $urandom % 2 == 0) d = m_pfmt | (d & ~m_pfm);
      if ((t == 3) && $urandom % 2 == 0) d = m_crs[idx[1:0]] ^ (d & ~m_crm[idx[1:0]]);
      if ((t == 6 || t == 7) && $urandom % 4 != 0) idx = idx % 256;
      if (t == 1) d = $urandom % 2;
      run_ev(t, idx, d);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule